// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block tracks a single shared line across a small group of private caches on a snooped bus. Each cache keeps its copy in one of four states: Invalid, Shared, Exclusive or Modified. At most one core presents a request in a given cycle. The request is a valid strobe, a core index and a read/write bit. In the cycle that accepts it, the block chooses the bus transaction, moves the requester and every snooping peer to their next states, and names the agent that returns the data.

Every output is registered, so the result of a request appears just after the clock edge that accepts it. Each cache is one state machine.

- The requester moves Invalid→Exclusive on a read with no holders.
- The requester moves Invalid→Shared on a read with holders.
- The requester moves Invalid→Modified on a write.
- The requester moves Shared→Modified on a write.
- The requester moves Exclusive→Modified on a silent write.
- A snooper on a bus read moves Modified→Shared or Exclusive→Shared.
- A snooper on a read-exclusive or an upgrade moves any state→Invalid.
- Every other case holds its state.

The bus command takes one of four values: idle, bus read, read-exclusive and upgrade. The upgrade only invalidates peers and moves no data.

Top module: `mesi_coh_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, every core's state is Invalid (0), `bus_cmd` is idle (0), `supplier` is 0 and `wb_flag` is 0. The state encoding is Invalid=0, Shared=1, Exclusive=2, Modified=3, and core k's state sits at `line_state[2k+1:2k]`.
- R2: A read from Invalid with no peer holding the line gives `bus_cmd`=1 (bus read) and `supplier`=1 (main memory), and the requester becomes Exclusive.
- R3: A read from Invalid with one or more valid peers gives `bus_cmd`=1 and leaves the requester and every valid peer in Shared. `supplier` is 2+k, where k is the lowest-numbered valid peer.
- R4: `wb_flag` is 1 exactly when a bus read is snooped by a peer in Modified.
- R5: A write in Exclusive moves to Modified with `bus_cmd`=0. A write in Modified keeps Modified with `bus_cmd`=0. In both cases no peer changes.
- R6: A write in Shared gives `bus_cmd`=3 (upgrade) and `supplier`=0. The writer becomes Modified and every peer becomes Invalid.
- R7: A write from Invalid gives `bus_cmd`=2 (read-exclusive). The writer becomes Modified and every peer becomes Invalid. `supplier` is 2+lowest valid peer, or 1 when no peer holds the line.
- R8: A read in Shared, Exclusive or Modified changes no state and gives `bus_cmd`=0 and `supplier`=0.
- R9: A cycle with `req_valid` low, or with `req_core` ≥ the core count, changes no state and gives `bus_cmd`=0, `supplier`=0 and `wb_flag`=0.
- R10: At most one core is Modified, and while one is Modified all others are Invalid.
- R11: The states, command, supplier and flag for a request all appear together after the single clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets every state to Invalid |
| req_valid | input | 1 | A request is present this cycle |
| req_core | input | 2 | Index of the requesting core |
| req_write | input | 1 | 1 = write, 0 = read |
| line_state | output | 6 | Two-bit state per core, with core 0 in the lowest bits |
| bus_cmd | output | 2 | Bus transaction: 0 idle, 1 read, 2 read-exclusive, 3 upgrade |
| supplier | output | 3 | Data source: 0 none, 1 memory, 2+k peer core k |
| wb_flag | output | 1 | A Modified copy is written back on a snooped read |

## Verification
The assertions check on every cycle that there is a single writer and that peers are invalid while a Modified copy exists. They also check that a write always leaves the writer Modified, that an upgrade or read-exclusive invalidates each snooper, that a read hit keeps its state, and that the supplier and write-back outputs agree with the bus command. Only the bench's scenarios can show that a given sequence yields the right states. This includes the replayed seven-step trace, supplier priority among several sharers, silent upgrades from Exclusive, and that requests naming a non-existent core are ignored.

// File: rtl/mesi_coh_pkg.sv
package mesi_coh_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2,
        LN_MOD = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_RDX  = 2'd2,
        BUS_UPG  = 2'd3
    } bus_op_t;
endpackage

// File: rtl/mesi_prio_pick.sv
module mesi_prio_pick #(
    parameter int WIDTH = 3,
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] hold_mask,
    output logic             found,
    output logic [IW-1:0]    index
);
    // Lowest set bit wins: scan downward so the last hit is the lowest.
    always_comb begin
        found = 1'b0;
        index = '0;
        for (int k = WIDTH - 1; k >= 0; k--) begin
            if (hold_mask[k]) begin
                found = 1'b1;
                index = IW'(k);
            end
        end
    end
endmodule

// File: rtl/mesi_bus_ctrl.sv
module mesi_bus_ctrl
    import mesi_coh_pkg::*;
#(
    parameter int N_CORES = 3,
    localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int SUP_W  = $clog2(N_CORES + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CORE_W-1:0]    req_core,
    input  logic                 req_write,
    input  logic [2*N_CORES-1:0] cur_flat,
    output logic                 req_ok,
    output bus_op_t              op_now,
    output logic                 peer_hold,
    output bus_op_t              bus_cmd_q,
    output logic [SUP_W-1:0]     supplier_q,
    output logic                 wb_q
);
    line_st_t            req_st;
    logic [N_CORES-1:0]  hold_mask;
    logic                peer_mod;
    logic                pick_found;
    logic [CORE_W-1:0]   pick_idx;
    logic [SUP_W-1:0]    supplier_d;
    logic                wb_d;

    assign req_ok = req_valid && (int'(req_core) < N_CORES);

    always_comb begin
        req_st   = LN_INV;
        peer_mod = 1'b0;
        for (int k = 0; k < N_CORES; k++) begin
            if (int'(req_core) == k) begin
                req_st       = line_st_t'(cur_flat[2*k +: 2]);
                hold_mask[k] = 1'b0;
            end else begin
                hold_mask[k] = (cur_flat[2*k +: 2] != LN_INV);
                if (cur_flat[2*k +: 2] == LN_MOD) peer_mod = 1'b1;
            end
        end
    end

    assign peer_hold = |hold_mask;

    mesi_prio_pick #(.WIDTH(N_CORES)) i_pick (
        .hold_mask (hold_mask),
        .found     (pick_found),
        .index     (pick_idx)
    );

    // Transaction selection from the requester's current state.
    always_comb begin
        op_now = BUS_IDLE;
        if (req_ok) begin
            unique case (req_st)
                LN_INV: op_now = req_write ? BUS_RDX : BUS_RD;
                LN_SHR: op_now = req_write ? BUS_UPG : BUS_IDLE;
                LN_EXC: op_now = BUS_IDLE;
                LN_MOD: op_now = BUS_IDLE;
            endcase
        end
    end

    always_comb begin
        supplier_d = '0;
        if (op_now == BUS_RD || op_now == BUS_RDX) begin
            supplier_d = pick_found ? SUP_W'(int'(pick_idx) + 2) : SUP_W'(1);
        end
        wb_d = (op_now == BUS_RD) && peer_mod;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_cmd_q  <= BUS_IDLE;
            supplier_q <= '0;
            wb_q       <= 1'b0;
        end else begin
            bus_cmd_q  <= op_now;
            supplier_q <= supplier_d;
            wb_q       <= wb_d;
        end
    end

    assert_idle_no_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_q == BUS_IDLE |-> (supplier_q == '0 && !wb_q));
    assert_upg_no_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_q == BUS_UPG |-> supplier_q == '0);
    assert_wb_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_q |-> bus_cmd_q == BUS_RD);
    assert_reject_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ok |=> bus_cmd_q == BUS_IDLE);
endmodule

// File: rtl/mesi_line_fsm.sv
module mesi_line_fsm
    import mesi_coh_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_ok,
    input  logic     i_am_req,
    input  logic     req_write,
    input  bus_op_t  op_now,
    input  logic     peer_hold,
    output line_st_t st_q
);
    line_st_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LN_INV;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (req_ok && i_am_req) begin
            unique case (st_q)
                LN_INV: st_d = req_write ? LN_MOD : (peer_hold ? LN_SHR : LN_EXC);
                LN_SHR: st_d = req_write ? LN_MOD : LN_SHR;
                LN_EXC: st_d = req_write ? LN_MOD : LN_EXC;
                LN_MOD: st_d = LN_MOD;
            endcase
        end else if (req_ok) begin
            unique case (op_now)
                BUS_IDLE: st_d = st_q;
                BUS_RD:   st_d = (st_q == LN_INV) ? LN_INV : LN_SHR;
                BUS_RDX:  st_d = LN_INV;
                BUS_UPG:  st_d = LN_INV;
            endcase
        end
    end

    assert_writer_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && i_am_req && req_write) |=> st_q == LN_MOD);
    assert_snoop_inval_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && !i_am_req && (op_now == BUS_UPG || op_now == BUS_RDX)) |=> st_q == LN_INV);
    assert_hit_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && i_am_req && !req_write && st_q != LN_INV) |=> $stable(st_q));
endmodule

// File: rtl/mesi_coh_ctrl.sv
module mesi_coh_ctrl
    import mesi_coh_pkg::*;
#(
    parameter int N_CORES = 3,
    localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int SUP_W  = $clog2(N_CORES + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CORE_W-1:0]    req_core,
    input  logic                 req_write,
    output logic [2*N_CORES-1:0] line_state,
    output logic [1:0]           bus_cmd,
    output logic [SUP_W-1:0]     supplier,
    output logic                 wb_flag
);
    logic    req_ok;
    logic    peer_hold;
    bus_op_t op_now;
    bus_op_t bus_cmd_q;

    mesi_bus_ctrl #(.N_CORES(N_CORES)) i_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_core   (req_core),
        .req_write  (req_write),
        .cur_flat   (line_state),
        .req_ok     (req_ok),
        .op_now     (op_now),
        .peer_hold  (peer_hold),
        .bus_cmd_q  (bus_cmd_q),
        .supplier_q (supplier),
        .wb_q       (wb_flag)
    );

    assign bus_cmd = bus_cmd_q;

    for (genvar k = 0; k < N_CORES; k++) begin : g_core
        line_st_t st;
        mesi_line_fsm i_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_ok    (req_ok),
            .i_am_req  (int'(req_core) == k),
            .req_write (req_write),
            .op_now    (op_now),
            .peer_hold (peer_hold),
            .st_q      (st)
        );
        assign line_state[2*k +: 2] = st;
    end

    // Single-writer invariant over the registered states.
    int m_cnt;
    int v_cnt;
    always_comb begin
        m_cnt = 0;
        v_cnt = 0;
        for (int k = 0; k < N_CORES; k++) begin
            if (line_state[2*k +: 2] == LN_MOD) m_cnt++;
            if (line_state[2*k +: 2] != LN_INV) v_cnt++;
        end
    end

    assert_single_writer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        m_cnt <= 1);
    assert_mod_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        m_cnt == 1 |-> v_cnt == 1);
endmodule

// File: tb/test_mesi_coh_ctrl.sv
module test_mesi_coh_ctrl;
    localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;
    localparam logic [1:0] C_ID = 2'd0, C_RD = 2'd1, C_RX = 2'd2, C_UP = 2'd3;

    typedef struct packed {
        logic       vld;
        logic [1:0] core;
        logic       wr;
        logic [5:0] st;
        logic [1:0] cmd;
        logic [2:0] sup;
        logic       wb;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TABLE [NV] = '{
        '{1'b1, 2'd1, 1'b0, {I, E, I}, C_RD, 3'd1, 1'b0}, // R2 read-2
        '{1'b1, 2'd1, 1'b1, {I, M, I}, C_ID, 3'd0, 1'b0}, // R5 write-2
        '{1'b1, 2'd0, 1'b0, {I, S, S}, C_RD, 3'd3, 1'b1}, // R4 read-1
        '{1'b1, 2'd0, 1'b1, {I, I, M}, C_UP, 3'd0, 1'b0}, // R6 write-1
        '{1'b1, 2'd1, 1'b0, {I, S, S}, C_RD, 3'd2, 1'b1}, // R3 read-2
        '{1'b1, 2'd0, 1'b0, {I, S, S}, C_ID, 3'd0, 1'b0}, // R8 read-1 hit
        '{1'b1, 2'd2, 1'b0, {S, S, S}, C_RD, 3'd2, 1'b0}, // R3 read-3
        '{1'b1, 2'd2, 1'b1, {M, I, I}, C_UP, 3'd0, 1'b0}, // R6 write-3
        '{1'b1, 2'd0, 1'b1, {I, I, M}, C_RX, 3'd4, 1'b0}, // R7 write-1 miss
        '{1'b1, 2'd0, 1'b1, {I, I, M}, C_ID, 3'd0, 1'b0}, // R5 write in M
        '{1'b1, 2'd2, 1'b0, {S, I, S}, C_RD, 3'd2, 1'b1}, // R4 read-3
        '{1'b1, 2'd1, 1'b0, {S, S, S}, C_RD, 3'd2, 1'b0}, // R3 lowest sharer
        '{1'b1, 2'd3, 1'b1, {S, S, S}, C_ID, 3'd0, 1'b0}, // R9 bad index
        '{1'b0, 2'd1, 1'b1, {S, S, S}, C_ID, 3'd0, 1'b0}  // R9 no valid
    };

    function automatic string tag_of(int row);
        case (row)
            0: return "R2";  1: return "R5";  2: return "R4";  3: return "R6";
            4: return "R3";  5: return "R8";  6: return "R3";  7: return "R6";
            8: return "R7";  9: return "R5"; 10: return "R4"; 11: return "R3";
            default: return "R9";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_core = '0;
    logic       req_write = 1'b0;
    logic [5:0] line_state;
    logic [1:0] bus_cmd;
    logic [2:0] supplier;
    logic       wb_flag;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    mesi_coh_ctrl i_mesi_coh_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
        .req_write(req_write), .line_state(line_state), .bus_cmd(bus_cmd),
        .supplier(supplier), .wb_flag(wb_flag)
    );

    task automatic check(string tag, logic [5:0] st, logic [1:0] cmd, logic [2:0] sup, logic wb);
        total++;
        if ({line_state, bus_cmd, supplier, wb_flag} !== {st, cmd, sup, wb}) begin
            bad++;
            $display("FAIL %s: state=%h cmd=%0d sup=%0d wb=%0d expected state=%h cmd=%0d sup=%0d wb=%0d",
                     tag, line_state, bus_cmd, supplier, wb_flag, st, cmd, sup, wb);
        end
    endtask

    // Drive at a falling edge, accept at the rising edge, check at the next falling edge (R11).
    task automatic issue(logic v, logic [1:0] c, logic w);
        @(negedge clk);
        req_valid = v; req_core = c; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #4_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {I, I, I}, C_ID, 3'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {I, I, I}, C_ID, 3'd0, 1'b0);

        for (int r = 0; r < NV; r++) begin
            issue(TABLE[r].vld, TABLE[r].core, TABLE[r].wr);
            check(tag_of(r), TABLE[r].st, TABLE[r].cmd, TABLE[r].sup, TABLE[r].wb);
        end

        // Reset in mid-run clears every copy.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", {I, I, I}, C_ID, 3'd0, 1'b0);
        rst_n = 1'b1;

        // Exclusive fill, silent upgrade, then a write miss served by the Modified peer.
        issue(1'b1, 2'd0, 1'b0);
        check("R2 fill from memory", {I, I, E}, C_RD, 3'd1, 1'b0);
        issue(1'b1, 2'd0, 1'b1);
        check("R5 silent E to M", {I, I, M}, C_ID, 3'd0, 1'b0);
        issue(1'b1, 2'd1, 1'b1);
        check("R7 rdx from M peer", {I, M, I}, C_RX, 3'd2, 1'b0);
        issue(1'b1, 2'd2, 1'b0);
        check("R4 read snoops M", {S, S, I}, C_RD, 3'd3, 1'b1);
        @(negedge clk);
        check("R9 idle cycle", {S, S, I}, C_ID, 3'd0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule